// File: doc/BRIEF.md
# Narrow Device Access Size Adapter

This block takes 32-bit read and write requests from the system side and serves them from an external device whose data bus is only 8 or 16 bits wide. Each chip-select has its own size bit, which sets the device width. A request is cut into successive external phases that climb in address, with bytes in little-endian order. Phases that carry no enabled byte are left out. Read bytes are gathered into a full word, and only then is a single response pulse raised.

The block does not generate the electrical waveform of an external phase. It hands each phase to a separate timing sequencer through a level request (`ph_start_o`) and a one-cycle completion strobe (`ph_done_i`). Traffic to 8-bit devices uses only the low byte lane. Such traffic is always marked as single-phase, whatever the multi-phase settings of that chip-select say.

Top module: `narrow_bus_adapter`

## Requirements
- R1: `cfg_wide_i[cs]` selects the device width of chip-select cs: 1 means a 16-bit device, where a 32-bit word becomes up to 2 phases; 0 means an 8-bit device, where it becomes up to 4 phases.
- R2: Phase k carries address `req_addr_i + k*W`, where W is the device width in bytes (1 or 2). Phases are issued in ascending k, so word byte i maps to byte address `req_addr_i + i` (little-endian).
- R3: For an 8-bit device a phase drives write byte i on `ph_wdata_o[7:0]`, with `ph_wdata_o[15:8]` = 0 and `ph_be_o[1]` = 0. Read data is taken from `ph_rdata_i[7:0]` only, and `ph_rdata_i[15:8]` is ignored.
- R4: For an 8-bit device `ph_multi_o` is 0 on every phase, even when `cfg_rd_multi_i` or `cfg_wr_multi_i` is set for that chip-select.
- R5: For a 16-bit device, phase k drives `req_wdata_i[16k+15:16k]` on `ph_wdata_o` and `req_be_i[2k+1:2k]` on `ph_be_o`. `ph_multi_o` equals `cfg_wr_multi_i[cs]` on writes and `cfg_rd_multi_i[cs]` on reads.
- R6: A phase whose byte enables are all zero is skipped. A request with `req_be_i` = 0 makes no phase and responds in the cycle after acceptance.
- R7: `rsp_valid_o` is a one-cycle pulse in the cycle after the edge that takes the last `ph_done_i`. At that time, byte i of `rsp_rdata_o` is the device byte for an enabled lane and 0 for a disabled lane.
- R8: After reset `req_ready_o` = 1, `ph_start_o` = 0 and `rsp_valid_o` = 0. `req_ready_o` is high only while idle. `ph_start_o` and the phase address stay stable until `ph_done_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cfg_wide_i | input | NUM_CS | Per chip-select width: 1 = 16-bit, 0 = 8-bit |
| cfg_rd_multi_i | input | NUM_CS | Per chip-select multi-phase read enable |
| cfg_wr_multi_i | input | NUM_CS | Per chip-select multi-phase write enable |
| req_valid_i | input | 1 | System request valid |
| req_ready_o | output | 1 | Request accepted when high with valid |
| req_we_i | input | 1 | 1 = write, 0 = read |
| req_cs_i | input | log2(NUM_CS) | Target chip-select |
| req_addr_i | input | AW | Request byte address |
| req_wdata_i | input | SYS_DW | Write word |
| req_be_i | input | SYS_DW/8 | Byte enables |
| rsp_valid_o | output | 1 | Response pulse |
| rsp_rdata_o | output | SYS_DW | Assembled read word |
| ph_start_o | output | 1 | Phase request to the timing sequencer |
| ph_we_o | output | 1 | Phase direction |
| ph_cs_o | output | log2(NUM_CS) | Phase chip-select |
| ph_addr_o | output | AW | Phase byte address |
| ph_wdata_o | output | 16 | Phase write data, lane-steered |
| ph_be_o | output | 2 | Phase lane enables |
| ph_multi_o | output | 1 | Multi-phase mode for this phase |
| ph_done_i | input | 1 | Phase complete strobe |
| ph_rdata_i | input | 16 | Phase read data |

## Verification
The first phase is due in the cycle after the accepting edge. Each later phase is due in the cycle after the edge that takes the previous `ph_done_i`. The response pulse comes one cycle after the last done, or one cycle after acceptance when no byte is enabled. The bench models the sequencer itself: it completes each phase after 0 to 2 extra cycles. It samples 2 ns after each rising edge and compares every phase field, `req_ready_o` and `rsp_valid_o` on every such cycle against the phase list and read word it derives from its own byte-memory model. It therefore catches a phase or response one cycle early or late, as well as wrong values.

// File: rtl/nba_pkg.sv
package nba_pkg;
  localparam int unsigned DEV_DW = 16;
  localparam int unsigned DEV_BE = DEV_DW / 8;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_PHASE = 2'd1,
    ST_RESP  = 2'd2
  } nba_state_e;
endpackage

// File: rtl/nba_phase_plan.sv
module nba_phase_plan #(
  parameter int unsigned BYTES = 4,
  localparam int unsigned IDX_W = $clog2(BYTES)
) (
  input  logic             wide_i,
  input  logic [BYTES-1:0] be_i,
  input  logic [IDX_W-1:0] cur_i,
  output logic             any_o,
  output logic [IDX_W-1:0] first_o,
  output logic             has_next_o,
  output logic [IDX_W-1:0] next_o
);
  logic [BYTES-1:0] en;

  // phase j is live when it owns at least one enabled byte
  for (genvar j = 0; j < BYTES; j++) begin : g_en
    if (2 * j + 1 < BYTES) begin : g_both
      assign en[j] = wide_i ? |be_i[2*j +: 2] : be_i[j];
    end else begin : g_narrow
      assign en[j] = !wide_i && be_i[j];
    end
  end

  always_comb begin
    any_o      = |en;
    first_o    = '0;
    has_next_o = 1'b0;
    next_o     = cur_i;
    for (int j = BYTES - 1; j >= 0; j--) begin
      if (en[j]) first_o = IDX_W'(j);
      if (en[j] && (IDX_W'(j) > cur_i)) begin
        has_next_o = 1'b1;
        next_o     = IDX_W'(j);
      end
    end
  end
endmodule

// File: rtl/nba_lane_steer.sv
module nba_lane_steer import nba_pkg::*; #(
  parameter int unsigned SYS_DW = 32,
  parameter int unsigned AW     = 32,
  localparam int unsigned BYTES = SYS_DW / 8,
  localparam int unsigned IDX_W = $clog2(BYTES)
) (
  input  logic              wide_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic [AW-1:0]     base_addr_i,
  input  logic [SYS_DW-1:0] wdata_i,
  input  logic [BYTES-1:0]  be_i,
  output logic [AW-1:0]     addr_o,
  output logic [DEV_DW-1:0] wdata_o,
  output logic [DEV_BE-1:0] be_o
);
  logic [SYS_DW-1:0] sh_half, sh_byte;
  logic [BYTES-1:0]  be_half, be_byte;
  logic [AW-1:0]     offs;

  always_comb begin
    sh_half = wdata_i >> {idx_i, 4'b0000};
    sh_byte = wdata_i >> {idx_i, 3'b000};
    be_half = be_i >> {idx_i, 1'b0};
    be_byte = be_i >> idx_i;
    offs    = wide_i ? (AW'(idx_i) << 1) : AW'(idx_i);
    addr_o  = base_addr_i + offs;
    // narrow devices live on the low lane only
    wdata_o = wide_i ? sh_half[DEV_DW-1:0] : {8'h00, sh_byte[7:0]};
    be_o    = wide_i ? be_half[DEV_BE-1:0] : {1'b0, be_byte[0]};
  end
endmodule

// File: rtl/nba_read_pack.sv
module nba_read_pack import nba_pkg::*; #(
  parameter int unsigned SYS_DW = 32,
  localparam int unsigned BYTES = SYS_DW / 8,
  localparam int unsigned IDX_W = $clog2(BYTES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clear_i,
  input  logic              cap_i,
  input  logic              wide_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic [BYTES-1:0]  be_i,
  input  logic [DEV_DW-1:0] rdata_i,
  output logic [SYS_DW-1:0] word_o
);
  for (genvar b = 0; b < BYTES; b++) begin : g_byte
    localparam int unsigned HALF = b / 2;
    localparam bit          HI   = (b % 2) == 1;
    logic [7:0] byte_q;
    logic       hit;
    logic [7:0] src;

    always_comb begin
      hit = wide_i ? (idx_i == IDX_W'(HALF)) : (idx_i == IDX_W'(b));
      src = (wide_i && HI) ? rdata_i[15:8] : rdata_i[7:0];
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                    byte_q <= '0;
      else if (clear_i)               byte_q <= '0;
      else if (cap_i && hit && be_i[b]) byte_q <= src;
    end

    assign word_o[b*8 +: 8] = byte_q;
  end
endmodule

// File: rtl/narrow_bus_adapter.sv
module narrow_bus_adapter import nba_pkg::*; #(
  parameter int unsigned SYS_DW = 32,
  parameter int unsigned AW     = 32,
  parameter int unsigned NUM_CS = 4,
  localparam int unsigned BYTES = SYS_DW / 8,
  localparam int unsigned IDX_W = $clog2(BYTES),
  localparam int unsigned CS_W  = $clog2(NUM_CS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NUM_CS-1:0] cfg_wide_i,
  input  logic [NUM_CS-1:0] cfg_rd_multi_i,
  input  logic [NUM_CS-1:0] cfg_wr_multi_i,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic              req_we_i,
  input  logic [CS_W-1:0]   req_cs_i,
  input  logic [AW-1:0]     req_addr_i,
  input  logic [SYS_DW-1:0] req_wdata_i,
  input  logic [BYTES-1:0]  req_be_i,
  output logic              rsp_valid_o,
  output logic [SYS_DW-1:0] rsp_rdata_o,
  output logic              ph_start_o,
  output logic              ph_we_o,
  output logic [CS_W-1:0]   ph_cs_o,
  output logic [AW-1:0]     ph_addr_o,
  output logic [DEV_DW-1:0] ph_wdata_o,
  output logic [DEV_BE-1:0] ph_be_o,
  output logic              ph_multi_o,
  input  logic              ph_done_i,
  input  logic [DEV_DW-1:0] ph_rdata_i
);
  nba_state_e        state_q;
  logic              we_q, wide_q, multi_q;
  logic [CS_W-1:0]   cs_q;
  logic [AW-1:0]     addr_q;
  logic [SYS_DW-1:0] wdata_q;
  logic [BYTES-1:0]  be_q;
  logic [IDX_W-1:0]  idx_q;

  logic              accept, ph_fin, req_wide, req_multi;
  logic              plan_wide, plan_any, plan_has_next;
  logic [BYTES-1:0]  plan_be;
  logic [IDX_W-1:0]  plan_first, plan_next;

  assign req_ready_o = (state_q == ST_IDLE);
  assign accept      = req_valid_i && req_ready_o;
  assign ph_fin      = (state_q == ST_PHASE) && ph_done_i;
  assign req_wide    = cfg_wide_i[req_cs_i];
  // multi-phase only meaningful on a 16-bit device
  assign req_multi   = req_wide && (req_we_i ? cfg_wr_multi_i[req_cs_i] : cfg_rd_multi_i[req_cs_i]);

  assign plan_wide = req_ready_o ? req_wide : wide_q;
  assign plan_be   = req_ready_o ? req_be_i : be_q;

  nba_phase_plan #(.BYTES(BYTES)) u_plan (
    .wide_i     (plan_wide),
    .be_i       (plan_be),
    .cur_i      (idx_q),
    .any_o      (plan_any),
    .first_o    (plan_first),
    .has_next_o (plan_has_next),
    .next_o     (plan_next)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      we_q    <= 1'b0;
      wide_q  <= 1'b0;
      multi_q <= 1'b0;
      cs_q    <= '0;
      addr_q  <= '0;
      wdata_q <= '0;
      be_q    <= '0;
      idx_q   <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (accept) begin
          we_q    <= req_we_i;
          wide_q  <= req_wide;
          multi_q <= req_multi;
          cs_q    <= req_cs_i;
          addr_q  <= req_addr_i;
          wdata_q <= req_wdata_i;
          be_q    <= req_be_i;
          idx_q   <= plan_first;
          state_q <= plan_any ? ST_PHASE : ST_RESP;
        end
        ST_PHASE: if (ph_done_i) begin
          if (plan_has_next) idx_q <= plan_next;
          else               state_q <= ST_RESP;
        end
        ST_RESP: state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  nba_lane_steer #(.SYS_DW(SYS_DW), .AW(AW)) u_steer (
    .wide_i      (wide_q),
    .idx_i       (idx_q),
    .base_addr_i (addr_q),
    .wdata_i     (wdata_q),
    .be_i        (be_q),
    .addr_o      (ph_addr_o),
    .wdata_o     (ph_wdata_o),
    .be_o        (ph_be_o)
  );

  nba_read_pack #(.SYS_DW(SYS_DW)) u_pack (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clear_i (accept),
    .cap_i   (ph_fin && !we_q),
    .wide_i  (wide_q),
    .idx_i   (idx_q),
    .be_i    (be_q),
    .rdata_i (ph_rdata_i),
    .word_o  (rsp_rdata_o)
  );

  assign ph_start_o  = (state_q == ST_PHASE);
  assign ph_we_o     = we_q;
  assign ph_cs_o     = cs_q;
  assign ph_multi_o  = ph_start_o && multi_q;
  assign rsp_valid_o = (state_q == ST_RESP);

  AST_NARROW_LANE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ph_start_o && !wide_q |-> (ph_wdata_o[15:8] == 8'h00) && !ph_be_o[1]); // R3
  AST_NARROW_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ph_start_o && !wide_q |-> !ph_multi_o); // R4
  AST_NO_EMPTY_PHASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ph_start_o |-> (ph_be_o != '0)); // R6
  AST_RSP_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |=> !rsp_valid_o); // R7
  AST_START_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ph_start_o && !ph_done_i |=> ph_start_o && $stable(ph_addr_o)); // R8
  AST_BUSY_NOT_READY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ph_start_o || rsp_valid_o) |-> !req_ready_o); // R8
endmodule

// File: tb/narrow_bus_adapter_tb_top.sv
module narrow_bus_adapter_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [3:0]  cfg_wide_i = '0, cfg_rd_multi_i = '0, cfg_wr_multi_i = '0;
  logic        req_valid_i = 1'b0, req_we_i = 1'b0;
  logic [1:0]  req_cs_i = '0;
  logic [31:0] req_addr_i = '0, req_wdata_i = '0;
  logic [3:0]  req_be_i = '0;
  logic        req_ready_o, rsp_valid_o, ph_start_o, ph_we_o, ph_multi_o;
  logic [31:0] rsp_rdata_o, ph_addr_o;
  logic [1:0]  ph_cs_o, ph_be_o;
  logic [15:0] ph_wdata_o;
  logic        ph_done_i = 1'b0;
  logic [15:0] ph_rdata_i = 16'hDEAD;

  int total = 0, bad = 0, cyc = 0, lat_seed = 0;
  bit finished = 0;
  logic [7:0] mem [256];

  always #4 clk_i = ~clk_i;

  narrow_bus_adapter dut_i (.*);

  always @(posedge clk_i) begin
    cyc++;
    if (cyc > 20000 && !finished) begin
      finished = 1;
      bad++; total++;
      $display("FAIL watchdog expired act=%0d exp<=20000", cyc);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic run_req(input logic we, input logic [1:0] cs, input logic [31:0] addr,
                         input logic [31:0] wdata, input logic [3:0] be);
    logic [31:0] ea [4];
    logic [15:0] ed [4];
    logic [1:0]  eb [4];
    int          cnt = 0;
    bit          wide = cfg_wide_i[cs];
    bit          multi = wide && (we ? cfg_wr_multi_i[cs] : cfg_rd_multi_i[cs]);
    logic [31:0] exp_rd = '0;
    int          nph = wide ? 2 : 4;
    for (int i = 0; i < 4; i++)
      if (be[i]) exp_rd[i*8 +: 8] = mem[8'(addr + 32'(i))];
    for (int k = 0; k < nph; k++) begin
      logic [1:0] lb = wide ? be[2*k +: 2] : {1'b0, be[k]};
      if (lb != 2'b00) begin
        ea[cnt] = addr + 32'(wide ? 2*k : k);
        ed[cnt] = wide ? wdata[16*k +: 16] : {8'h00, wdata[8*k +: 8]};
        eb[cnt] = lb;
        cnt++;
      end
    end
    chk("R8 ready when idle", 32'(req_ready_o), 32'd1);
    req_valid_i = 1; req_we_i = we; req_cs_i = cs; req_addr_i = addr;
    req_wdata_i = wdata; req_be_i = be;
    @(posedge clk_i); #2;
    req_valid_i = 0;
    for (int p = 0; p < cnt; p++) begin
      int lat = lat_seed % 3;
      lat_seed++;
      for (int l = 0; l <= lat; l++) begin
        chk("R8 phase start", 32'(ph_start_o), 32'd1);
        chk("R8 busy not ready", 32'(req_ready_o), 32'd0);
        chk("R7 no early rsp", 32'(rsp_valid_o), 32'd0);
        chk("R2 phase addr", ph_addr_o, ea[p]);
        chk("R1 phase we/cs", {ph_we_o, ph_cs_o}, {we, cs});
        chk(wide ? "R5 phase be" : "R3 phase be", 32'(ph_be_o), 32'(eb[p]));
        if (we) chk(wide ? "R5 phase wdata" : "R3 phase wdata", 32'(ph_wdata_o), 32'(ed[p]));
        chk(wide ? "R5 multi" : "R4 narrow multi", 32'(ph_multi_o), 32'(multi));
        if (l == lat) begin
          logic [7:0] a0 = ea[p][7:0];
          ph_done_i = 1;
          ph_rdata_i = wide ? {mem[a0 + 8'd1], mem[a0]} : {8'hA5, mem[a0]};
        end
        @(posedge clk_i); #2;
        ph_done_i = 0; ph_rdata_i = 16'hDEAD;
      end
    end
    if (cnt == 0) chk("R6 empty request no phase", 32'(ph_start_o), 32'd0);
    chk("R7 rsp after last phase", 32'(rsp_valid_o), 32'd1);
    chk("R7 no phase during rsp", 32'(ph_start_o), 32'd0);
    if (!we) chk("R7 read word", rsp_rdata_o, exp_rd);
    if (we) for (int i = 0; i < 4; i++)
      if (be[i]) mem[8'(addr + 32'(i))] = wdata[i*8 +: 8];
    @(posedge clk_i); #2;
    chk("R7 rsp one cycle", 32'(rsp_valid_o), 32'd0);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 8'(i * 7 + 3);
    #20;
    chk("R8 reset ready", 32'(req_ready_o), 32'd1);
    chk("R8 reset start", 32'(ph_start_o), 32'd0);
    chk("R8 reset rsp", 32'(rsp_valid_o), 32'd0);
    @(negedge clk_i); rst_ni = 1;
    @(posedge clk_i); #2;
    cfg_wide_i = 4'b0010; cfg_rd_multi_i = 4'b0011; cfg_wr_multi_i = 4'b0011;
    // R1 R3 R4: narrow cs0, multi set but forced off
    run_req(1, 2'd0, 32'h10, 32'h44332211, 4'hF);
    run_req(0, 2'd0, 32'h10, 32'h0, 4'hF);
    // R1 R5: wide cs1, multi on
    run_req(1, 2'd1, 32'h40, 32'hCAFEBABE, 4'hF);
    run_req(0, 2'd1, 32'h40, 32'h0, 4'hF);
    // R6: skipped phases, partial enables
    run_req(1, 2'd1, 32'h50, 32'h12345678, 4'b1100);
    run_req(0, 2'd1, 32'h50, 32'h0, 4'b0110);
    run_req(1, 2'd0, 32'h60, 32'h9ABCDEF0, 4'b0100);
    run_req(0, 2'd0, 32'h60, 32'h0, 4'b1010);
    // R6: nothing enabled
    run_req(1, 2'd0, 32'h70, 32'hFFFFFFFF, 4'b0000);
    run_req(0, 2'd1, 32'h70, 32'h0, 4'b0000);
    // R5: wide cs2, multi off for reads only
    cfg_wide_i = 4'b0110; cfg_rd_multi_i = 4'b0000; cfg_wr_multi_i = 4'b0100;
    run_req(1, 2'd2, 32'h80, 32'h0BADF00D, 4'hF);
    run_req(0, 2'd2, 32'h80, 32'h0, 4'hF);
    run_req(0, 2'd3, 32'h81, 32'h0, 4'hF);
    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule